// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Bridge

This block sits between a host CPU bus and an embedded coprocessor and gives the host a small byte-wide register window. Through that window the host can hand one byte to the coprocessor, collect one byte from it, read a status byte, acknowledge an attention flag, and hold or release the coprocessor in reset. The coprocessor side has matching read and write strobes for both single-byte mailboxes. It also has a down-counting timer with a load strobe.

The window is decoded loosely. Address bit 0 and address bits 7:3 are ignored, so the eight-byte register set repeats across a whole 256-byte page. Reads have side effects: reading the return mailbox empties it, and reading the attention register clears the attention flag. A 0-to-1 write of the hold bit restarts the coprocessor, which clears every flag and the timer. When the hold is released, a fixed boot delay runs before the bridge reports the coprocessor as ready and lets it run.

When one side sets a flag in the same cycle as the other side clears it, the set wins. A coprocessor restart overrides both.

Top module: `cmb_bridge`

## Requirements
- R1: A host access hits the window only when host_addr[22] is 0 and host_addr[15:8] is 0x38. Inside the window host_addr[2:1] selects the register (0: return mailbox, 1: attention/forward mailbox, 2: control/status, 3: unused), and bits 23, 21:16, 7:3 and 0 are ignored. Any read that is a miss, or that selects register 3, returns 0x00. Any write that is a miss, or that selects register 0 or register 3, changes no state.
- R2: A host read of register 0 returns the coprocessor-to-host byte and clears that mailbox's ready flag when the flag is set. When the flag is clear, the read returns 0x00.
- R3: A host write of register 1 latches host_wdata into the host-to-coprocessor mailbox and sets its ready flag. A host read of register 1 returns 0x00 and clears the attention flag.
- R4: A host read of register 2 returns the status byte and has no side effect. The status bits are: bit 0 coprocessor-to-host ready, bit 2 attention, bit 3 host-to-coprocessor ready, bit 7 boot-ready. All other bits are 0.
- R5: A host write of register 2 stores host_wdata[0] as the hold level and ignores the other data bits. A 0-to-1 change of the hold level restarts the coprocessor. The restart clears boot-ready, attention, both mailbox ready flags, the timer count and the timer latch, and it wins over any set in the same cycle.
- R6: While hold is 1, boot-ready stays 0. Once hold is 0 and boot-ready is 0, boot-ready is set on the BOOT_CYCLES-th rising edge (default 65536), counted from the first edge at which hold is 0. cp_run is high only when boot-ready is 1 and hold is 0.
- R7: cp_tmr_ld loads cp_tmr_val into both the timer count and the timer latch. On every other edge the count decrements by one if it is nonzero, and it stays at zero once it reaches zero.
- R8: cp_rdata always shows the host-to-coprocessor byte, and cp_rd clears that mailbox's ready flag. cp_wr latches cp_wdata into the coprocessor-to-host mailbox and sets its ready flag. When cp_wr_sig is also high, cp_wr sets the attention flag as well.
- R9: When a set and a clear of the same flag fall in the same cycle, the flag ends up set. A host read of the return mailbox in that cycle returns the value it had before the edge.
- R10: After system reset, hold is 0, all flags, data and the timer are clear, and the boot delay starts on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 24 | Host bus address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the strobe cycle |
| cp_rd | input | 1 | Coprocessor read strobe of the host-to-coprocessor mailbox |
| cp_rdata | output | 8 | Host-to-coprocessor byte |
| cp_wr | input | 1 | Coprocessor write strobe of the coprocessor-to-host mailbox |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_wr_sig | input | 1 | With cp_wr, also raise the attention flag |
| cp_tmr_ld | input | 1 | Timer load strobe |
| cp_tmr_val | input | TW | Timer load value |
| cp_tmr_cnt | output | TW | Current timer count |
| cp_tmr_latch | output | TW | Last loaded timer value |
| cp_h2c_ready | output | 1 | Host-to-coprocessor mailbox holds an unread byte |
| cp_c2h_ready | output | 1 | Coprocessor-to-host mailbox holds an unread byte |
| cp_run | output | 1 | Coprocessor may execute |

## Verification
A host access and a coprocessor access can land on the same flag in the same cycle. Examples are a host read of the return mailbox against a coprocessor write, an attention read against an attention-raising write, and a host forward write against a coprocessor read. Directed cycles drive each pair together with the flag both clear and set. A constrained-random phase then mixes both sides freely every cycle. In each of these cycles a bench model applies the set-wins rule to predict the read data and the next status. A restart write is also driven in the same cycle as a coprocessor write, and the bench expects the restart to leave every flag clear.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

  typedef enum logic [1:0] {
    SEL_C2H  = 2'd0,
    SEL_SIG  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int ST_C2H  = 0;
  localparam int ST_SIG  = 2;
  localparam int ST_H2C  = 3;
  localparam int ST_BOOT = 7;

  typedef struct packed {
    logic rd_c2h;
    logic rd_sig;
    logic wr_h2c;
    logic rd_stat;
    logic wr_ctl;
  } host_op_t;

endpackage

// File: rtl/cmb_decode.sv
module cmb_decode
  import cmb_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [7:0] PAGE = 8'h38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output host_op_t      op
);

  logic     in_win;
  reg_sel_e sel;
  logic     unused_addr;

  assign unused_addr = ^{addr[AW-1:23], addr[21:16], addr[7:3], addr[0]};
  assign in_win      = ~addr[22] & (addr[15:8] == PAGE);
  assign sel         = reg_sel_e'(addr[2:1]);

  always_comb begin
    op = '0;
    if (in_win) begin
      unique case (sel)
        SEL_C2H:  op.rd_c2h = rd;
        SEL_SIG:  begin
          op.rd_sig = rd;
          op.wr_h2c = wr;
        end
        SEL_CTL:  begin
          op.rd_stat = rd;
          op.wr_ctl  = wr;
        end
        default:  op = '0;
      endcase
    end
  end

  // R1: at most one read-type and one write-type operation per access
  p_one_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op.rd_c2h, op.rd_sig, op.rd_stat}));
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op.wr_h2c, op.wr_ctl}));
  p_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[22] || addr[15:8] != PAGE) |-> (op == '0));

endmodule

// File: rtl/cmb_flag.sv
module cmb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_nxt;

  always_comb begin
    if (wipe)      q_nxt = 1'b0;
    else if (set)  q_nxt = 1'b1;
    else if (clr)  q_nxt = 1'b0;
    else           q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !wipe) |=> q);
  p_wipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !q);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr && !wipe) |=> $stable(q));

endmodule

// File: rtl/cmb_mailbox.sv
module cmb_mailbox #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         ready,
  output logic [W-1:0] data
);

  logic [W-1:0] data_nxt;
  logic         data_en;

  assign data_en  = push;
  assign data_nxt = push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (data_en) data <= data_nxt;
  end

  cmb_flag i_ready (
    .clk   (clk),
    .rst_n (rst_n),
    .wipe  (wipe),
    .set   (push),
    .clr   (pop),
    .q     (ready)
  );

  p_push_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (data == $past(push_data)));
  p_data_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(data));

endmodule

// File: rtl/cmb_boot.sv
module cmb_boot #(
  parameter int unsigned CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic hold,
  output logic ready
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          ready_nxt;

  always_comb begin
    cnt_nxt   = cnt;
    ready_nxt = ready;
    if (wipe) begin
      cnt_nxt   = '0;
      ready_nxt = 1'b0;
    end else if (hold) begin
      cnt_nxt   = '0;
    end else if (!ready) begin
      if (cnt == LAST) begin
        cnt_nxt   = '0;
        ready_nxt = 1'b1;
      end else begin
        cnt_nxt   = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      ready <= ready_nxt;
    end
  end

  p_rise_unheld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(hold));
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ready) |=> !ready);
  p_wipe_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !ready);

endmodule

// File: rtl/cmb_timer.sv
module cmb_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic [TW-1:0] cnt,
  output logic [TW-1:0] latch
);

  logic [TW-1:0] cnt_nxt, latch_nxt;

  always_comb begin
    cnt_nxt   = cnt;
    latch_nxt = latch;
    if (wipe) begin
      cnt_nxt   = '0;
      latch_nxt = '0;
    end else if (ld) begin
      cnt_nxt   = ld_val;
      latch_nxt = ld_val;
    end else if (cnt != '0) begin
      cnt_nxt   = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
    end else begin
      cnt   <= cnt_nxt;
      latch <= latch_nxt;
    end
  end

  p_timer_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && !ld && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_timer_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && !ld && cnt == '0) |=> (cnt == '0));
  p_timer_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && ld) |=> (cnt == $past(ld_val) && latch == $past(ld_val)));

endmodule

// File: rtl/cmb_bridge.sv
module cmb_bridge
  import cmb_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 8,
  parameter int          TW          = 16,
  parameter int unsigned BOOT_CYCLES = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          cp_rd,
  output logic [DW-1:0] cp_rdata,
  input  logic          cp_wr,
  input  logic [DW-1:0] cp_wdata,
  input  logic          cp_wr_sig,
  input  logic          cp_tmr_ld,
  input  logic [TW-1:0] cp_tmr_val,
  output logic [TW-1:0] cp_tmr_cnt,
  output logic [TW-1:0] cp_tmr_latch,
  output logic          cp_h2c_ready,
  output logic          cp_c2h_ready,
  output logic          cp_run
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  host_op_t      op;
  logic          hold, hold_nxt;
  logic          wipe;
  logic          sig;
  logic          boot_ready;
  logic [DW-1:0] c2h_data;
  logic [DW-1:0] status;

  cmb_decode #(.AW(AW)) i_decode (
    .clk   (clk),
    .rst_n (rst_sn),
    .rd    (host_rd),
    .wr    (host_wr),
    .addr  (host_addr),
    .op    (op)
  );

  // hold level and restart detection
  assign wipe     = op.wr_ctl & host_wdata[0] & ~hold;
  assign hold_nxt = op.wr_ctl ? host_wdata[0] : hold;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) hold <= 1'b0;
    else         hold <= hold_nxt;
  end

  cmb_mailbox #(.W(DW)) i_h2c (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wipe      (wipe),
    .push      (op.wr_h2c),
    .push_data (host_wdata),
    .pop       (cp_rd),
    .ready     (cp_h2c_ready),
    .data      (cp_rdata)
  );

  cmb_mailbox #(.W(DW)) i_c2h (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wipe      (wipe),
    .push      (cp_wr),
    .push_data (cp_wdata),
    .pop       (op.rd_c2h),
    .ready     (cp_c2h_ready),
    .data      (c2h_data)
  );

  cmb_flag i_sig (
    .clk   (clk),
    .rst_n (rst_sn),
    .wipe  (wipe),
    .set   (cp_wr & cp_wr_sig),
    .clr   (op.rd_sig),
    .q     (sig)
  );

  cmb_boot #(.CYCLES(BOOT_CYCLES)) i_boot (
    .clk   (clk),
    .rst_n (rst_sn),
    .wipe  (wipe),
    .hold  (hold),
    .ready (boot_ready)
  );

  cmb_timer #(.TW(TW)) i_timer (
    .clk    (clk),
    .rst_n  (rst_sn),
    .wipe   (wipe),
    .ld     (cp_tmr_ld),
    .ld_val (cp_tmr_val),
    .cnt    (cp_tmr_cnt),
    .latch  (cp_tmr_latch)
  );

  always_comb begin
    status          = '0;
    status[ST_C2H]  = cp_c2h_ready;
    status[ST_SIG]  = sig;
    status[ST_H2C]  = cp_h2c_ready;
    status[ST_BOOT] = boot_ready;
  end

  always_comb begin
    host_rdata = '0;
    if (op.rd_c2h && cp_c2h_ready) host_rdata = c2h_data;
    else if (op.rd_stat)           host_rdata = status;
  end

  assign cp_run = boot_ready & ~hold;

  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    cp_run |-> !hold);
  p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_rd && !cp_c2h_ready && !op.rd_stat) |-> (host_rdata == '0));
  p_ctl_bit0_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    op.wr_ctl |=> (hold == $past(host_wdata[0])));
  p_sig_read_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    op.rd_sig |-> (host_rdata == '0));

endmodule

// File: tb/test_cmb_bridge.sv
module test_cmb_bridge;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_rd, host_wr;
  logic [23:0]   host_addr;
  logic [7:0]    host_wdata, host_rdata;
  logic          cp_rd, cp_wr, cp_wr_sig, cp_tmr_ld;
  logic [7:0]    cp_rdata, cp_wdata;
  logic [TW-1:0] cp_tmr_val, cp_tmr_cnt, cp_tmr_latch;
  logic          cp_h2c_ready, cp_c2h_ready, cp_run;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cmb_bridge #(.TW(TW)) i_cmb_bridge (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd      (host_rd),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .cp_rd        (cp_rd),
    .cp_rdata     (cp_rdata),
    .cp_wr        (cp_wr),
    .cp_wdata     (cp_wdata),
    .cp_wr_sig    (cp_wr_sig),
    .cp_tmr_ld    (cp_tmr_ld),
    .cp_tmr_val   (cp_tmr_val),
    .cp_tmr_cnt   (cp_tmr_cnt),
    .cp_tmr_latch (cp_tmr_latch),
    .cp_h2c_ready (cp_h2c_ready),
    .cp_c2h_ready (cp_c2h_ready),
    .cp_run       (cp_run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hits(input logic [23:0] a);
    return (a[22] == 1'b0) && (a[15:8] == 8'h38);
  endfunction

  function automatic logic [7:0] mk_stat(input logic c2h, sg, h2c, boot);
    return {boot, 3'b000, h2c, sg, 1'b0, c2h};
  endfunction

  // one bus cycle: drive at negedge, sample before the edge, release after it
  task automatic cyc(input logic hrd, input logic hwr, input logic [23:0] ha,
                     input logic [7:0] hd, input logic crd, input logic cwr,
                     input logic [7:0] cd, input logic csig, input logic tld,
                     input logic [TW-1:0] tv, output logic [7:0] hq, output logic [7:0] cq);
    @(negedge clk);
    host_rd = hrd; host_wr = hwr; host_addr = ha; host_wdata = hd;
    cp_rd = crd; cp_wr = cwr; cp_wdata = cd; cp_wr_sig = csig;
    cp_tmr_ld = tld; cp_tmr_val = tv;
    #1;
    hq = host_rdata; cq = cp_rdata;
    @(posedge clk);
    #1;
    host_rd = 0; host_wr = 0; cp_rd = 0; cp_wr = 0; cp_wr_sig = 0; cp_tmr_ld = 0;
  endtask

  task automatic hwrite(input logic [23:0] a, input logic [7:0] d);
    logic [7:0] x, y;
    cyc(0, 1, a, d, 0, 0, 8'h00, 0, 0, '0, x, y);
  endtask

  task automatic hread(input logic [23:0] a, output logic [7:0] q);
    logic [7:0] y;
    cyc(1, 0, a, 8'h00, 0, 0, 8'h00, 0, 0, '0, q, y);
  endtask

  // status read within one cycle, no clock edge crossed
  task automatic peek(output logic [7:0] st);
    host_rd = 1; host_addr = 24'h003804;
    #1;
    st = host_rdata;
    host_rd = 0;
  endtask

  initial begin
    #(8 * 195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, c, st;
    logic m_c2h, m_sig, m_h2c;
    logic [7:0] m_c2h_d, m_h2c_d;
    void'($urandom(32'h5eed_c0de));

    host_rd = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    cp_rd = 0; cp_wr = 0; cp_wdata = '0; cp_wr_sig = 0; cp_tmr_ld = 0; cp_tmr_val = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R10: clean state after system reset
    peek(st);
    chk("R10 status after reset", st, 8'h00);
    chk("R10 run low after reset", cp_run, 0);
    chk("R10 timer after reset", cp_tmr_cnt, 0);

    // R10/R6: boot delay starts on its own
    repeat (65540) @(posedge clk);
    #1; peek(st);
    chk("R10 boot-ready after first delay", st, 8'h80);
    chk("R6 run after boot", cp_run, 1);

    // R3 + R1: forward byte through a mirror (bank 0x80, bit0 set, bit3 set)
    hwrite(24'h80380B, 8'h5A);
    peek(st);
    chk("R3 forward ready in status", st, 8'h88);
    chk("R8 cp_rdata shows forward byte", cp_rdata, 8'h5A);
    cyc(0, 0, 24'h0, 8'h0, 1, 0, 8'h0, 0, 0, '0, q, c);
    chk("R8 cp read returns byte", c, 8'h5A);
    peek(st);
    chk("R8 cp read clears ready", st, 8'h80);

    // R8 + R2 + R4: return byte with attention
    cyc(0, 0, 24'h0, 8'h0, 0, 1, 8'hA7, 1, 0, '0, q, c);
    peek(st);
    chk("R4 status layout c2h+sig+boot", st, 8'h85);
    hread(24'h3F38F1, q);
    chk("R2 read returns byte", q, 8'hA7);
    peek(st);
    chk("R2 read clears ready", st, 8'h84);
    hread(24'h003800, q);
    chk("R2 empty read returns zero", q, 8'h00);
    hread(24'h003802, q);
    chk("R3 attention read returns zero", q, 8'h00);
    peek(st);
    chk("R3 attention read clears flag", st, 8'h80);

    // R1: misses and unused registers
    hwrite(24'h403802, 8'h11);
    hwrite(24'h003902, 8'h12);
    hwrite(24'h003806, 8'h13);
    hwrite(24'h003800, 8'h14);
    peek(st);
    chk("R1 miss/unused writes ignored", st, 8'h80);
    chk("R1 cp_rdata untouched", cp_rdata, 8'h5A);
    cyc(0, 0, 24'h0, 8'h0, 0, 1, 8'h66, 1, 0, '0, q, c);
    hread(24'hC03800, q);
    chk("R1 miss read zero", q, 8'h00);
    hread(24'h003806, q);
    chk("R1 unused read zero", q, 8'h00);
    peek(st);
    chk("R1 miss read has no side effect", st, 8'h85);

    // R9: collisions, flag set beforehand
    cyc(1, 0, 24'h003800, 8'h0, 0, 1, 8'h77, 0, 0, '0, q, c);
    chk("R9 read during write returns old", q, 8'h66);
    peek(st);
    chk("R9 c2h set wins", st[0], 1);
    cyc(1, 0, 24'h003802, 8'h0, 0, 1, 8'h78, 1, 0, '0, q, c);
    peek(st);
    chk("R9 sig set wins", st[2], 1);
    hread(24'h003800, q);
    chk("R9 newest byte kept", q, 8'h78);
    hread(24'h003800, q);
    chk("R9 empty after pop", q, 8'h00);
    // flag clear beforehand
    cyc(1, 0, 24'h003800, 8'h0, 0, 1, 8'h79, 0, 0, '0, q, c);
    chk("R9 empty read during write is zero", q, 8'h00);
    peek(st);
    chk("R9 c2h set from empty", st[0], 1);
    cyc(0, 1, 24'h003802, 8'hC3, 1, 0, 8'h0, 0, 0, '0, q, c);
    chk("R9 h2c set wins", cp_h2c_ready, 1);
    chk("R9 new forward byte", cp_rdata, 8'hC3);

    // R7: timer
    cyc(0, 0, 24'h0, 8'h0, 0, 0, 8'h0, 0, 1, 16'd5, q, c);
    chk("R7 load count", cp_tmr_cnt, 5);
    chk("R7 load latch", cp_tmr_latch, 5);
    for (int i = 4; i >= 0; i--) begin
      @(posedge clk); #1;
      chk("R7 decrement", cp_tmr_cnt, i);
    end
    repeat (3) @(posedge clk); #1;
    chk("R7 floor at zero", cp_tmr_cnt, 0);
    chk("R7 latch kept", cp_tmr_latch, 5);

    // random mixed traffic against bench model (R1,R2,R3,R8,R9)
    hread(24'h003800, q);
    hread(24'h003802, q);
    cyc(0, 0, 24'h0, 8'h0, 1, 0, 8'h0, 0, 0, '0, q, c);
    m_c2h = 0; m_sig = 0; m_h2c = 0; m_c2h_d = 8'h79; m_h2c_d = 8'hC3;
    for (int n = 0; n < 3000; n++) begin
      logic hrd, hwr, crd, cwr, csg, hit;
      logic [1:0] sel;
      logic [23:0] a;
      logic [7:0] hd, cd, eq;
      a   = $urandom;
      if ($urandom_range(0, 7) != 0) begin a[22] = 0; a[15:8] = 8'h38; end
      hrd = $urandom_range(0, 1);
      hwr = !hrd && $urandom_range(0, 1);
      if (hwr && a[2:1] == 2'd2) a[2:1] = 2'd3;
      crd = $urandom_range(0, 2) == 0;
      cwr = $urandom_range(0, 2) == 0;
      csg = $urandom_range(0, 1);
      hd  = $urandom; cd = $urandom;
      hit = hits(a); sel = a[2:1];
      eq = 8'h00;
      if (hrd && hit && sel == 2'd0 && m_c2h) eq = m_c2h_d;
      if (hrd && hit && sel == 2'd2) eq = mk_stat(m_c2h, m_sig, m_h2c, 1'b1);
      cyc(hrd, hwr, a, hd, crd, cwr, cd, csg, 0, '0, q, c);
      chk("R9 random host read data", q, eq);
      chk("R8 random cp read data", c, m_h2c_d);
      if (cwr) begin m_c2h = 1; m_c2h_d = cd; end
      else if (hrd && hit && sel == 2'd0) m_c2h = 0;
      if (cwr && csg) m_sig = 1;
      else if (hrd && hit && sel == 2'd1) m_sig = 0;
      if (hwr && hit && sel == 2'd1) begin m_h2c = 1; m_h2c_d = hd; end
      else if (crd) m_h2c = 0;
    end
    peek(st);
    chk("R4 status after random", st, mk_stat(m_c2h, m_sig, m_h2c, 1'b1));

    // R5: restart clears everything; wins over a cp write in the same cycle
    hwrite(24'h003802, 8'h31);
    cyc(0, 0, 24'h0, 8'h0, 0, 0, 8'h0, 0, 1, 16'd900, q, c);
    cyc(0, 1, 24'h003805, 8'hFF, 0, 1, 8'h42, 1, 0, '0, q, c);
    peek(st);
    chk("R5 restart clears status", st, 8'h00);
    chk("R5 restart clears timer", cp_tmr_cnt, 0);
    chk("R5 restart clears latch", cp_tmr_latch, 0);
    chk("R6 run low in hold", cp_run, 0);

    // R5: writing 1 again while held is not a restart
    hwrite(24'h003802, 8'h32);
    hwrite(24'h003804, 8'h01);
    peek(st);
    chk("R5 repeated hold keeps flags", st, 8'h08);
    repeat (100) @(posedge clk); #1;
    peek(st);
    chk("R6 boot-ready stays low in hold", st[7], 0);

    // R6: exact boot delay after release (bit 0 = 0, other bits ignored)
    hwrite(24'h003804, 8'hFE);
    repeat (65535) @(posedge clk); #1;
    peek(st);
    chk("R6 not ready one edge early", st[7], 0);
    chk("R6 run low one edge early", cp_run, 0);
    @(posedge clk); #1;
    peek(st);
    chk("R6 ready at exact edge", st[7], 1);
    chk("R6 run after release", cp_run, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule